// File: doc/BRIEF.md
# Two-Tier Cell-Averaging CFAR Detector

This block grades every range cell of one Doppler column against a locally estimated noise floor. A whole column of unsigned magnitudes is accepted on a valid/ready input stream. For each cell under test, the block averages the training cells on both sides of it. It skips the guard cells next to the cell under test and the cell itself. It then compares the cell with two thresholds, each scaled by its own Q4.4 factor. The result is a 2-bit class for each cell, returned on a valid/ready output stream in range order.

The guard count, training count, both scale factors, the enable and the detector mode are plain runtime inputs. They are captured once per column, when the last sample of the column is accepted. Suggested host settings are guard 2, training 8, confirm factor 8'h30 (3.0) and soft factor 8'h18 (1.5). Back-pressure rules are as follows. The input is ready only while a column is being filled. The output is valid only while a column is being graded. A class that is offered but not taken stays on the output unchanged until it is taken.

Top module: `cfar_two_tier`

## Requirements
- R1: After reset, s_ready is 1 and m_valid is 0. s_ready stays 1 until exactly COL_LEN samples have been accepted. s_ready is then 0 and m_valid is 1 until COL_LEN classes have been taken, after which s_ready returns to 1.
- R2: While m_valid is 1 and m_ready is 0, m_valid and m_class hold their values into the next cycle.
- R3: m_class encodes 2'b00 as none, 2'b01 as candidate and 2'b10 as confirmed. 2'b11 is never produced. Classes come out in the order the samples arrived, one per sample.
- R4: For the cell at index i, with guard count G and training count T (both per side), the training cells are indices i-G-T to i-G-1 and i+G+1 to i+G+T. The cell under test and the guard cells are never averaged.
- R5: Training indices outside 0 to COL_LEN-1 are dropped, so only the cells that exist are averaged. If no training cell exists (for example T = 0), the class is none.
- R6: The noise estimate is floor(sum of training cells / number of training cells). A right shift is used when the count is a power of two.
- R7: Each threshold is floor(alpha × noise / 16), with alpha a Q4.4 factor. The class is confirmed if cell > confirm threshold. Otherwise it is candidate if cell > soft threshold, and otherwise none. Both comparisons are strict.
- R8: If the captured enable is 0, or the captured mode is not 2'b00 (cell averaging), every cell of that column is classed none.
- R9: The configuration inputs are sampled when the last sample of a column is accepted. Changing them while the column is being graded has no effect on that column's classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input magnitude valid |
| s_ready | output | 1 | Block can accept a magnitude |
| s_data | input | DATA_W | Unsigned magnitude, range order |
| m_valid | output | 1 | Class output valid |
| m_ready | input | 1 | Downstream takes the class |
| m_class | output | 2 | Detection class of current cell |
| cfg_guard | input | CNT_W | Guard cells per side |
| cfg_train | input | CNT_W | Training cells per side |
| cfg_alpha_conf | input | 8 | Confirm factor, Q4.4 |
| cfg_alpha_soft | input | 8 | Soft factor, Q4.4 |
| cfg_enable | input | 1 | 0 forces every class to none |
| cfg_mode | input | 2 | 2'b00 selects cell averaging |

## Verification
The bench goes after the column edges. A design that did not drop missing training cells would average stale or wrapped data there, or divide by the full count and under-estimate the noise. It also aims at counts that are not powers of two, where a design that always shifted would produce a wrong noise floor. A flat column with factor 1.0 exposes a greater-or-equal comparison by flagging every cell. Training count zero exposes a divide by zero. A configuration changed during grading catches a design that reads live inputs instead of captured ones. Random stalls on both streams would make a design that drops or repeats a class misalign every later cell.

// File: rtl/cfar_pkg.sv
package cfar_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_CAND = 2'b01,
    CLS_CONF = 2'b10
  } cfar_class_e;

  localparam logic [1:0] MODE_CELL_AVG = 2'b00;
  localparam int         ALPHA_W       = 8;
  localparam int         ALPHA_FRAC    = 4;
  localparam logic [7:0] ALPHA_CONF_DEF = 8'h30;
  localparam logic [7:0] ALPHA_SOFT_DEF = 8'h18;
  localparam int         GUARD_DEF     = 2;
  localparam int         TRAIN_DEF     = 8;
endpackage

// File: rtl/cfar_col_buf.sv
module cfar_col_buf #(
  parameter int DATA_W  = 16,
  parameter int COL_LEN = 32,
  parameter int IDX_W   = $clog2(COL_LEN)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            s_valid,
  input  logic [DATA_W-1:0]               s_data,
  output logic                            s_ready,
  input  logic                            m_ready,
  output logic                            m_valid,
  output logic                            cap_o,
  output logic [IDX_W-1:0]                rd_idx_o,
  output logic [COL_LEN-1:0][DATA_W-1:0]  cells_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(COL_LEN - 1);

  logic             grading_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [COL_LEN-1:0][DATA_W-1:0] cells_q;

  assign s_ready  = !grading_q;
  assign m_valid  = grading_q;
  assign cap_o    = !grading_q && s_valid && (wr_idx_q == LAST);
  assign rd_idx_o = rd_idx_q;
  assign cells_o  = cells_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grading_q <= 1'b0;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
    end else if (!grading_q) begin
      if (s_valid) begin
        if (wr_idx_q == LAST) begin
          wr_idx_q  <= '0;
          grading_q <= 1'b1;
        end else begin
          wr_idx_q <= wr_idx_q + 1'b1;
        end
      end
    end else if (m_ready) begin
      if (rd_idx_q == LAST) begin
        rd_idx_q  <= '0;
        grading_q <= 1'b0;
      end else begin
        rd_idx_q <= rd_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!grading_q && s_valid) cells_q[wr_idx_q] <= s_data;
  end
endmodule

// File: rtl/cfar_window_sum.sv
module cfar_window_sum #(
  parameter int DATA_W  = 16,
  parameter int COL_LEN = 32,
  parameter int IDX_W   = $clog2(COL_LEN),
  parameter int CNT_W   = 4,
  parameter int TOT_W   = CNT_W + 1,
  parameter int SUM_W   = DATA_W + TOT_W
) (
  input  logic [COL_LEN-1:0][DATA_W-1:0] cells_i,
  input  logic [IDX_W-1:0]               cut_i,
  input  logic [CNT_W-1:0]               guard_i,
  input  logic [CNT_W-1:0]               train_i,
  output logic [SUM_W-1:0]               sum_o,
  output logic [TOT_W-1:0]               cnt_o
);
  always_comb begin
    int cut, g, t, n;
    logic [SUM_W-1:0] acc;
    cut = int'(cut_i);
    g   = int'(guard_i);
    t   = int'(train_i);
    n   = 0;
    acc = '0;
    for (int j = 0; j < COL_LEN; j++) begin
      if ((j >= cut - g - t && j <= cut - g - 1) ||
          (j >= cut + g + 1 && j <= cut + g + t)) begin
        acc = acc + SUM_W'(cells_i[j]);
        n   = n + 1;
      end
    end
    sum_o = acc;
    cnt_o = TOT_W'(n);
  end
endmodule

// File: rtl/cfar_noise_div.sv
module cfar_noise_div #(
  parameter int DATA_W = 16,
  parameter int TOT_W  = 5,
  parameter int SUM_W  = DATA_W + TOT_W
) (
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [TOT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] noise_o
);
  logic             pow2;
  logic [SUM_W-1:0] quot;

  assign pow2 = (cnt_i != '0) && ((cnt_i & (cnt_i - 1'b1)) == '0);

  always_comb begin
    int sh;
    sh = 0;
    for (int b = 0; b < TOT_W; b++) if (cnt_i[b]) sh = b;
    if (cnt_i == '0)  quot = '0;
    else if (pow2)    quot = sum_i >> sh;
    else              quot = sum_i / SUM_W'(cnt_i);
  end

  assign noise_o = quot[DATA_W-1:0];
endmodule

// File: rtl/cfar_classify.sv
module cfar_classify
  import cfar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]  cell_i,
  input  logic [DATA_W-1:0]  noise_i,
  input  logic [ALPHA_W-1:0] alpha_conf_i,
  input  logic [ALPHA_W-1:0] alpha_soft_i,
  input  logic               active_i,
  output cfar_class_e        class_o
);
  localparam int PROD_W = DATA_W + ALPHA_W;

  logic [PROD_W-1:0] thr_conf, thr_soft, cell_x;

  assign thr_conf = (PROD_W'(alpha_conf_i) * PROD_W'(noise_i)) >> ALPHA_FRAC;
  assign thr_soft = (PROD_W'(alpha_soft_i) * PROD_W'(noise_i)) >> ALPHA_FRAC;
  assign cell_x   = PROD_W'(cell_i);

  always_comb begin
    if (!active_i)               class_o = CLS_NONE;
    else if (cell_x > thr_conf)  class_o = CLS_CONF;
    else if (cell_x > thr_soft)  class_o = CLS_CAND;
    else                         class_o = CLS_NONE;
  end
endmodule

// File: rtl/cfar_two_tier.sv
module cfar_two_tier
  import cfar_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COL_LEN = 32,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [1:0]        m_class,
  input  logic [CNT_W-1:0]  cfg_guard,
  input  logic [CNT_W-1:0]  cfg_train,
  input  logic [7:0]        cfg_alpha_conf,
  input  logic [7:0]        cfg_alpha_soft,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode
);
  localparam int IDX_W = $clog2(COL_LEN);
  localparam int TOT_W = CNT_W + 1;
  localparam int SUM_W = DATA_W + TOT_W;

  logic                           cap;
  logic [IDX_W-1:0]               cut;
  logic [COL_LEN-1:0][DATA_W-1:0] cells;
  logic [SUM_W-1:0]               win_sum;
  logic [TOT_W-1:0]               win_cnt;
  logic [DATA_W-1:0]              noise;
  cfar_class_e                    cls;

  logic [CNT_W-1:0] guard_q, train_q;
  logic [7:0]       aconf_q, asoft_q;
  logic             en_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guard_q <= CNT_W'(GUARD_DEF);
      train_q <= CNT_W'(TRAIN_DEF);
      aconf_q <= ALPHA_CONF_DEF;
      asoft_q <= ALPHA_SOFT_DEF;
      en_q    <= 1'b0;
      mode_q  <= MODE_CELL_AVG;
    end else if (cap) begin
      guard_q <= cfg_guard;
      train_q <= cfg_train;
      aconf_q <= cfg_alpha_conf;
      asoft_q <= cfg_alpha_soft;
      en_q    <= cfg_enable;
      mode_q  <= cfg_mode;
    end
  end

  cfar_col_buf #(.DATA_W(DATA_W), .COL_LEN(COL_LEN), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .m_ready(m_ready), .m_valid(m_valid),
    .cap_o(cap), .rd_idx_o(cut), .cells_o(cells)
  );

  cfar_window_sum #(.DATA_W(DATA_W), .COL_LEN(COL_LEN), .IDX_W(IDX_W),
                    .CNT_W(CNT_W), .TOT_W(TOT_W), .SUM_W(SUM_W)) u_win (
    .cells_i(cells), .cut_i(cut), .guard_i(guard_q), .train_i(train_q),
    .sum_o(win_sum), .cnt_o(win_cnt)
  );

  cfar_noise_div #(.DATA_W(DATA_W), .TOT_W(TOT_W), .SUM_W(SUM_W)) u_div (
    .sum_i(win_sum), .cnt_i(win_cnt), .noise_o(noise)
  );

  cfar_classify #(.DATA_W(DATA_W)) u_cls (
    .cell_i(cells[cut]), .noise_i(noise),
    .alpha_conf_i(aconf_q), .alpha_soft_i(asoft_q),
    .active_i(en_q && (mode_q == MODE_CELL_AVG) && (win_cnt != '0)),
    .class_o(cls)
  );

  assign m_class = cls;
endmodule

// File: rtl/cfar_two_tier_chk.sv
module cfar_two_tier_chk #(
  parameter int COL_LEN = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [1:0] m_class
);
  localparam int IDX_W = $clog2(COL_LEN);
  logic [IDX_W-1:0] in_cnt, out_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (s_valid && s_ready)
        in_cnt <= (in_cnt == IDX_W'(COL_LEN - 1)) ? '0 : in_cnt + 1'b1;
      if (m_valid && m_ready)
        out_cnt <= (out_cnt == IDX_W'(COL_LEN - 1)) ? '0 : out_cnt + 1'b1;
    end
  end

  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_class != 2'b11));

  a_r1_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  a_r1_fill_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && in_cnt != IDX_W'(COL_LEN - 1)) |=> s_ready);

  a_r1_drain_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && out_cnt != IDX_W'(COL_LEN - 1)) |=> m_valid);

  a_r1_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && in_cnt == IDX_W'(COL_LEN - 1)) |=> m_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_class)));
endmodule

bind cfar_two_tier cfar_two_tier_chk #(.COL_LEN(COL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_class(m_class)
);

// File: tb/cfar_two_tier_bench.sv
module cfar_two_tier_bench;
  localparam int N  = 32;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [1:0]    m_class;
  logic [CW-1:0] cfg_guard = '0;
  logic [CW-1:0] cfg_train = '0;
  logic [7:0]    cfg_alpha_conf = '0;
  logic [7:0]    cfg_alpha_soft = '0;
  logic          cfg_enable = 1'b0;
  logic [1:0]    cfg_mode = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int col_data [N];

  always #5 clk = ~clk;

  cfar_two_tier #(.DATA_W(DW), .COL_LEN(N), .CNT_W(CW)) u_cfar_two_tier (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_class(m_class),
    .cfg_guard(cfg_guard), .cfg_train(cfg_train),
    .cfg_alpha_conf(cfg_alpha_conf), .cfg_alpha_soft(cfg_alpha_soft),
    .cfg_enable(cfg_enable), .cfg_mode(cfg_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // R4/R5/R6/R7/R8: reference class from the requirement text
  function automatic int ref_class(int i, int g, int t, int ac, int as, bit en, int md);
    longint sum = 0;
    int n = 0;
    longint noise, tc, ts;
    for (int k = 1; k <= t; k++) begin
      if (i - g - k >= 0) begin sum += col_data[i - g - k]; n++; end
      if (i + g + k < N)  begin sum += col_data[i + g + k]; n++; end
    end
    if (!en || md != 0 || n == 0) return 0;
    noise = sum / n;
    tc = (ac * noise) / 16;
    ts = (as * noise) / 16;
    if (col_data[i] > tc) return 2;
    if (col_data[i] > ts) return 1;
    return 0;
  endfunction

  task automatic run_column(input int g, input int t, input int ac, input int as,
                            input bit en, input int md, input bit disturb, input string tag);
    int exp_cls [N];
    int got, prev_cls;
    bit stalled;
    cfg_guard = CW'(g); cfg_train = CW'(t);
    cfg_alpha_conf = 8'(ac); cfg_alpha_soft = 8'(as);
    cfg_enable = en; cfg_mode = 2'(md);
    for (int i = 0; i < N; i++) exp_cls[i] = ref_class(i, g, t, ac, as, en, md);
    // fill, with random gaps
    for (int i = 0; i < N; i++) begin
      while ($urandom_range(3) == 0) begin
        @(negedge clk);
        s_valid = 1'b0;
        check(m_valid == 1'b0, "R1 idle while filling", int'(m_valid), 0);
      end
      @(negedge clk);
      check(s_ready == 1'b1, "R1 ready while filling", int'(s_ready), 1);
      s_valid = 1'b1;
      s_data  = DW'(col_data[i]);
    end
    @(negedge clk);
    s_valid = 1'b0;
    check(s_ready == 1'b0 && m_valid == 1'b1, "R1 grading after full column",
          int'({s_ready, m_valid}), 1);
    if (disturb) begin  // R9: live inputs change while grading
      cfg_guard = CW'(g + 3); cfg_train = CW'(t + 1);
      cfg_alpha_conf = 8'(ac + 7); cfg_alpha_soft = 8'(as + 5);
      cfg_enable = ~en; cfg_mode = 2'(md + 1);
    end
    got = 0;
    stalled = 1'b0;
    prev_cls = 0;
    while (got < N) begin
      if (stalled)
        check(m_valid && int'(m_class) == prev_cls, "R2 class held under stall",
              int'(m_class), prev_cls);
      check(m_class != 2'b11, "R3 reserved code", int'(m_class), 0);
      m_ready = ($urandom_range(3) != 0);
      if (m_valid && m_ready) begin
        check(int'(m_class) == exp_cls[got], tag, int'(m_class), exp_cls[got]);
        got++;
        stalled = 1'b0;
      end else begin
        stalled = m_valid;
        prev_cls = int'(m_class);
      end
      @(negedge clk);
    end
    m_ready = 1'b0;
    check(s_ready == 1'b1 && m_valid == 1'b0, "R1 ready after drain",
          int'({s_ready, m_valid}), 2);
  endtask

  task automatic fill_noise(input int lo, input int hi);
    for (int i = 0; i < N; i++) col_data[i] = $urandom_range(hi, lo);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check(s_ready == 1'b0 || s_ready == 1'b1, "R1 reset defined", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b1, "R1 reset s_ready", int'(s_ready), 1);
    check(m_valid == 1'b0, "R1 reset m_valid", int'(m_valid), 0);

    // defaults: guard 2, train 8, confirm 3.0, soft 1.5
    fill_noise(90, 110);
    col_data[10] = 400; col_data[20] = 200; col_data[0] = 500; col_data[31] = 180;
    run_column(2, 8, 8'h30, 8'h18, 1, 0, 0, "R7 default tiers");

    // flat column, factor 1.0: strict compare gives none
    for (int i = 0; i < N; i++) col_data[i] = 50;
    run_column(1, 4, 8'h10, 8'h10, 1, 0, 0, "R7 strict compare flat");

    // guard cells must not be averaged: big values sit in the guard band
    for (int i = 0; i < N; i++) col_data[i] = 20;
    col_data[15] = 100; col_data[14] = 5000; col_data[16] = 5000;
    run_column(1, 2, 8'h30, 8'h18, 1, 0, 0, "R4 guard excluded");

    fill_noise(90, 110); col_data[5] = 900;
    run_column(2, 8, 8'h30, 8'h18, 0, 0, 0, "R8 enable low");
    run_column(2, 8, 8'h30, 8'h18, 1, 1, 0, "R8 mode not cell averaging");
    run_column(2, 0, 8'h30, 8'h18, 1, 0, 0, "R5 no training cells");

    fill_noise(0, 300); col_data[0] = 2000; col_data[N-1] = 900;
    run_column(15, 15, 8'h20, 8'h12, 1, 0, 0, "R5 edge partial window");
    run_column(0, 3, 8'h18, 8'h14, 1, 0, 0, "R6 non power of two count");
    run_column(0, 1, 8'h18, 8'h11, 1, 0, 0, "R6 small window");
    run_column(2, 8, 8'h30, 8'h18, 1, 0, 1, "R9 config captured");

    for (int c = 0; c < 40; c++) begin
      fill_noise(0, $urandom_range(2000, 10));
      for (int s = 0; s < 4; s++) col_data[$urandom_range(N-1)] = $urandom_range(65535);
      run_column($urandom_range(15), $urandom_range(15), $urandom_range(255),
                 $urandom_range(255), ($urandom_range(7) != 0),
                 ($urandom_range(5) == 0) ? $urandom_range(3) : 0,
                 $urandom_range(1), "R3 random column");
    end
    finish_run();
  end
endmodule